// File: doc/BRIEF.md
# GPIO and Control Register File

This block is a 16-bit register file that sits on a simple synchronous bus with a select strobe, a write enable, a byte address, write data and registered read data. It stores six plain control words: mode, clock divider, clock control, interrupt request/mode, interrupt mask and interrupt status. It also holds a power word with a self-setting side effect and a fixed status word. Interrupt, clock and power words are storage only. They drive nothing inside the block.

The same register file owns a 16-line general-purpose port. A direction word selects which lines drive. A level word holds the value written by the bus or captured from external input lines. The driven vector is the level masked by direction. It is recomputed only when the bus writes the direction word or the level word. On each recomputation a one-cycle change vector flags exactly the output lines that toggled. External input lines can set or clear level bits at any time, but they do not move the outputs until the next recomputation.

Top module: `gpio_ctl_regs`

## Requirements
- R1: After reset every readable word reads 0x0000, except status (offset 0x08), which reads 0x0002. `gpio_out` and `gpio_chg` are 0x0000.
- R2: Mode (0x00), clock divider (0x04), clock control (0x10), interrupt request/mode (0x14), interrupt mask (0x18) and interrupt status (0x1C) store the low 16 bits of the write data and read them back. Upper write-data bits are discarded.
- R3: A write to power (0x0C) stores the low 16 bits of the data. When bit 7 of that data is 1, bits 15 and 6 are also set (OR with 0x8040).
- R4: Writes to status (0x08) have no effect. It always reads 0x0002.
- R5: Only address bits [5:0] are decoded, so an address plus any multiple of 0x40 reaches the same word.
- R6: Offsets outside the eleven listed here (for example 0x01, 0x2C, 0x3C) read 0x0000, and writes to them change no register.
- R7: A write to 0x24 or 0x28 stores (write data AND direction) into the level word. Reads of 0x24 and 0x28 return the level word, and reads of 0x20 return the direction word.
- R8: A write to direction (0x20) or to level (0x24/0x28) sets `gpio_out` to level AND direction, visible from the clock edge that takes the write.
- R9: On that same edge `gpio_chg` shows, for one cycle, exactly the bits where the new `gpio_out` differs from the old one. In every other cycle it is zero.
- R10: When `pin_upd[i]` is 1, level bit i takes `pin_val[i]` whatever the direction. This alone never changes `gpio_out`.
- R11: When a bus level write and a pin update land in the same cycle, the bus write decides every level bit.
- R12: A read (select high, write enable low) updates `bus_rdata` on the next clock edge, and `bus_rdata` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address, only bits [5:0] decoded |
| bus_wdata | input | BUS_W (32) | Write data, truncated to 16 bits |
| bus_rdata | output | 16 | Registered read data |
| pin_upd | input | 16 | Per-line input update enable |
| pin_val | input | 16 | Per-line input level |
| gpio_out | output | 16 | Driven output vector (level AND direction) |
| gpio_chg | output | 16 | One-cycle toggle flags per output line |

## Verification
The port logic is driven with level writes through both level offsets, both wider and narrower than the current direction mask, and with direction changes over a fixed level. This separates masking on store from masking on output, and the change vector shows whether only the toggled bits are flagged. Pin updates are applied both inside and outside the direction mask, with an output check after each one. This tells a design that recomputes outputs on input activity apart from one that waits for a bus write. A bus level write and a pin update are then driven in the same cycle, which shows which source wins. Aliased, undecoded and read-only offsets are written with all-ones patterns and then read back next to a known word, so that a stray write would be visible.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  localparam int DW     = 16;
  localparam int OFF_W  = 6;
  localparam int NPLAIN = 6;

  localparam logic [OFF_W-1:0] OFF_MODE   = 6'h00;
  localparam logic [OFF_W-1:0] OFF_CLKDIV = 6'h04;
  localparam logic [OFF_W-1:0] OFF_STAT   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_POWER  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_CLKCTL = 6'h10;
  localparam logic [OFF_W-1:0] OFF_IRQREQ = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IRQMSK = 6'h18;
  localparam logic [OFF_W-1:0] OFF_IRQSTA = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_DIR    = 6'h20;
  localparam logic [OFF_W-1:0] OFF_LVLW   = 6'h24;
  localparam logic [OFF_W-1:0] OFF_LVLR   = 6'h28;

  localparam logic [DW-1:0] STATUS_VAL = 16'h0002;

  // plain storage slot indices
  localparam int P_MODE   = 0;
  localparam int P_CLKDIV = 1;
  localparam int P_CLKCTL = 2;
  localparam int P_IRQREQ = 3;
  localparam int P_IRQMSK = 4;
  localparam int P_IRQSTA = 5;

  typedef struct packed {
    logic mode;
    logic clkdiv;
    logic stat;
    logic power;
    logic clkctl;
    logic irqreq;
    logic irqmsk;
    logic irqsta;
    logic dir;
    logic lvlw;
    logic lvlr;
  } regsel_t;
endpackage

// File: rtl/gpio_ctl_decode.sv
module gpio_ctl_decode
  import gpio_ctl_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  output regsel_t          hit
);
  always_comb begin
    hit = '0;
    case (off)
      OFF_MODE:   hit.mode   = 1'b1;
      OFF_CLKDIV: hit.clkdiv = 1'b1;
      OFF_STAT:   hit.stat   = 1'b1;
      OFF_POWER:  hit.power  = 1'b1;
      OFF_CLKCTL: hit.clkctl = 1'b1;
      OFF_IRQREQ: hit.irqreq = 1'b1;
      OFF_IRQMSK: hit.irqmsk = 1'b1;
      OFF_IRQSTA: hit.irqsta = 1'b1;
      OFF_DIR:    hit.dir    = 1'b1;
      OFF_LVLW:   hit.lvlw   = 1'b1;
      OFF_LVLR:   hit.lvlr   = 1'b1;
      default:    hit = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ctl_store.sv
module gpio_ctl_store
  import gpio_ctl_pkg::*;
#(
  parameter int              W          = DW,
  parameter int              TRIG_BIT   = 7,
  parameter logic [W-1:0]    FORCE_MASK = 16'h8040
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  regsel_t                   hit,
  input  logic [W-1:0]              wdata,
  output logic [NPLAIN-1:0][W-1:0]  plain_q,
  output logic [W-1:0]              power_q
);
  logic [NPLAIN-1:0] plain_we;
  logic [W-1:0]      power_nxt;
  logic              power_we;

  always_comb begin
    plain_we           = '0;
    plain_we[P_MODE]   = wr_en & hit.mode;
    plain_we[P_CLKDIV] = wr_en & hit.clkdiv;
    plain_we[P_CLKCTL] = wr_en & hit.clkctl;
    plain_we[P_IRQREQ] = wr_en & hit.irqreq;
    plain_we[P_IRQMSK] = wr_en & hit.irqmsk;
    plain_we[P_IRQSTA] = wr_en & hit.irqsta;
  end

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    logic [W-1:0] nxt;
    always_comb nxt = plain_we[g] ? wdata : plain_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) plain_q[g] <= '0;
      else        plain_q[g] <= nxt;
    end
  end

  always_comb begin
    power_we  = wr_en & hit.power;
    power_nxt = power_q;
    if (power_we)
      power_nxt = wdata | (wdata[TRIG_BIT] ? FORCE_MASK : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) power_q <= '0;
    else        power_q <= power_nxt;
  end

  // R3: trigger bit forces the extra bits
  a_r3_power_force: assert property (@(posedge clk) disable iff (!rst_n)
    (power_we && wdata[TRIG_BIT]) |=> ((power_q & FORCE_MASK) == FORCE_MASK));

  // R2: mode word moves only on its own write
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !plain_we[P_MODE] |=> $stable(plain_q[P_MODE]));
endmodule

// File: rtl/gpio_ctl_port.sv
module gpio_ctl_port #(
  parameter int NLINE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             lvl_wr,
  input  logic [NLINE-1:0] wdata,
  input  logic [NLINE-1:0] pin_upd,
  input  logic [NLINE-1:0] pin_val,
  output logic [NLINE-1:0] dir_q,
  output logic [NLINE-1:0] lvl_q,
  output logic [NLINE-1:0] out_q,
  output logic [NLINE-1:0] chg_q
);
  logic [NLINE-1:0] dir_nxt, lvl_nxt, out_nxt, chg_nxt, eval;
  logic             reeval;

  // per-line level source: bus write beats pin update
  for (genvar i = 0; i < NLINE; i++) begin : g_lvl
    always_comb begin
      if (lvl_wr)          lvl_nxt[i] = wdata[i] & dir_q[i];
      else if (pin_upd[i]) lvl_nxt[i] = pin_val[i];
      else                 lvl_nxt[i] = lvl_q[i];
    end
  end

  always_comb begin
    reeval  = dir_wr | lvl_wr;
    dir_nxt = dir_wr ? wdata : dir_q;
    eval    = lvl_nxt & dir_nxt;
    out_nxt = reeval ? eval : out_q;
    chg_nxt = reeval ? (eval ^ out_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      out_q <= '0;
      chg_q <= '0;
    end else begin
      dir_q <= dir_nxt;
      lvl_q <= lvl_nxt;
      out_q <= out_nxt;
      chg_q <= chg_nxt;
    end
  end

  // R7: stored level never exceeds the direction seen at write time
  a_r7_lvl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> ((lvl_q & ~$past(dir_q)) == '0));

  // R8: outputs only drive lines configured as outputs
  a_r8_out_within_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q & ~dir_q) == '0);

  // R9: change flags equal the actual output toggle
  a_r9_chg_exact: assert property (@(posedge clk) disable iff (!rst_n)
    reeval |=> (chg_q == (out_q ^ $past(out_q))));

  // R9: no flags without a recomputation
  a_r9_chg_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !reeval |=> (chg_q == '0));

  // R10: pin activity alone leaves outputs alone
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reeval |=> $stable(out_q));
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_ctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     pin_upd,
  input  logic [DW-1:0]     pin_val,
  output logic [DW-1:0]     gpio_out,
  output logic [DW-1:0]     gpio_chg
);
  regsel_t                   hit;
  logic                      wr_en, rd_en;
  logic [DW-1:0]             wdata16;
  logic [NPLAIN-1:0][DW-1:0] plain_q;
  logic [DW-1:0]             power_q, dir_q, lvl_q;
  logic [DW-1:0]             rd_mux, rdata_q, rdata_nxt;
  logic                      unused_hi;

  assign wr_en     = bus_sel &  bus_we;
  assign rd_en     = bus_sel & ~bus_we;
  assign wdata16   = bus_wdata[DW-1:0];
  assign unused_hi = ^{bus_wdata[BUS_W-1:DW], bus_addr[ADDR_W-1:OFF_W]};

  gpio_ctl_decode u_dec (
    .off (bus_addr[OFF_W-1:0]),
    .hit (hit)
  );

  gpio_ctl_store #(.W(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .hit     (hit),
    .wdata   (wdata16),
    .plain_q (plain_q),
    .power_q (power_q)
  );

  gpio_ctl_port #(.NLINE(DW)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_wr  (wr_en & hit.dir),
    .lvl_wr  (wr_en & (hit.lvlw | hit.lvlr)),
    .wdata   (wdata16),
    .pin_upd (pin_upd),
    .pin_val (pin_val),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .out_q   (gpio_out),
    .chg_q   (gpio_chg)
  );

  always_comb begin
    rd_mux = '0;
    if (hit.mode)                  rd_mux = plain_q[P_MODE];
    else if (hit.clkdiv)           rd_mux = plain_q[P_CLKDIV];
    else if (hit.stat)             rd_mux = STATUS_VAL;
    else if (hit.power)            rd_mux = power_q;
    else if (hit.clkctl)           rd_mux = plain_q[P_CLKCTL];
    else if (hit.irqreq)           rd_mux = plain_q[P_IRQREQ];
    else if (hit.irqmsk)           rd_mux = plain_q[P_IRQMSK];
    else if (hit.irqsta)           rd_mux = plain_q[P_IRQSTA];
    else if (hit.dir)              rd_mux = dir_q;
    else if (hit.lvlw | hit.lvlr)  rd_mux = lvl_q;
    rdata_nxt = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign bus_rdata = rdata_q;

  // R6/R5: at most one word selected by any offset
  a_r6_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R12: read data only moves after a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_ctl_regs_test.sv
`timescale 1ns/1ps
module gpio_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [15:0] bus_rdata, pin_upd, pin_val, gpio_out, gpio_chg;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_upd(pin_upd), .pin_val(pin_val), .gpio_out(gpio_out), .gpio_chg(gpio_chg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pins(input logic [15:0] m, input logic [15:0] v);
    @(negedge clk);
    pin_upd = m; pin_val = v;
    @(negedge clk);
    pin_upd = '0;
  endtask

  task automatic t_reset();
    check("R1 gpio_out", gpio_out, 16'h0);
    check("R1 gpio_chg", gpio_chg, 16'h0);
    for (int a = 0; a < 12'h2C; a += 4)
      rd_chk("R1 reset read", a[11:0], (a == 8) ? 16'h0002 : 16'h0000);
  endtask

  task automatic t_storage();
    wr(12'h000, 32'hABCD_1234);
    wr(12'h004, 32'hFFFF_2222);
    wr(12'h010, 32'h0000_3333);
    wr(12'h014, 32'h0001_4444);
    wr(12'h018, 32'h8000_5555);
    wr(12'h01C, 32'h0000_6666);
    rd_chk("R2 mode trunc", 12'h000, 16'h1234);
    rd_chk("R2 clkdiv", 12'h004, 16'h2222);
    rd_chk("R2 clkctl", 12'h010, 16'h3333);
    rd_chk("R2 irqreq", 12'h014, 16'h4444);
    rd_chk("R2 irqmask", 12'h018, 16'h5555);
    rd_chk("R2 irqstat", 12'h01C, 16'h6666);
  endtask

  task automatic t_power();
    wr(12'h00C, 32'h0000_0080);
    rd_chk("R3 power trigger", 12'h00C, 16'h80C0);
    wr(12'h00C, 32'h0000_0001);
    rd_chk("R3 power plain", 12'h00C, 16'h0001);
    wr(12'h00C, 32'h1234_5F7F);
    rd_chk("R3 power no trigger", 12'h00C, 16'h5F7F);
    wr(12'h00C, 32'h0000_0A80);
    rd_chk("R3 power merge", 12'h00C, 16'h8AC0);
  endtask

  task automatic t_status();
    wr(12'h008, 32'h0000_FFFF);
    rd_chk("R4 status read-only", 12'h008, 16'h0002);
  endtask

  task automatic t_alias();
    wr(12'h044, 32'h0000_5A5A);
    rd_chk("R5 alias write", 12'h004, 16'h5A5A);
    rd_chk("R5 alias read", 12'hFC4, 16'h5A5A);
  endtask

  task automatic t_undecoded();
    wr(12'h001, 32'hFFFF_FFFF);
    wr(12'h02C, 32'hFFFF_FFFF);
    wr(12'h03C, 32'hFFFF_FFFF);
    rd_chk("R6 undecoded 0x01", 12'h001, 16'h0000);
    rd_chk("R6 undecoded 0x2C", 12'h02C, 16'h0000);
    rd_chk("R6 undecoded 0x3C", 12'h03C, 16'h0000);
    rd_chk("R6 mode untouched", 12'h000, 16'h1234);
    rd_chk("R6 clkdiv untouched", 12'h004, 16'h5A5A);
    rd_chk("R6 dir untouched", 12'h020, 16'h0000);
    check("R6 gpio_out untouched", gpio_out, 16'h0000);
  endtask

  task automatic t_gpio();
    wr(12'h020, 32'h0000_00FF);
    check("R8 dir only, level zero", gpio_out, 16'h0000);
    check("R9 no toggle", gpio_chg, 16'h0000);
    wr(12'h024, 32'h0000_FFFF);
    check("R8 out after level write", gpio_out, 16'h00FF);
    check("R9 chg after level write", gpio_chg, 16'h00FF);
    @(negedge clk);
    check("R9 chg one cycle", gpio_chg, 16'h0000);
    rd_chk("R7 level via 0x24", 12'h024, 16'h00FF);
    rd_chk("R7 level via 0x28", 12'h028, 16'h00FF);
    rd_chk("R7 dir via 0x20", 12'h020, 16'h00FF);
    wr(12'h020, 32'h0000_0F0F);
    check("R8 out after dir shrink", gpio_out, 16'h000F);
    check("R9 chg after dir shrink", gpio_chg, 16'h00F0);
    rd_chk("R7 level kept on dir write", 12'h024, 16'h00FF);
    wr(12'h020, 32'h0000_FFFF);
    check("R8 out after dir grow", gpio_out, 16'h00FF);
    check("R9 chg after dir grow", gpio_chg, 16'h00F0);
    wr(12'h028, 32'h0000_0F0F);
    check("R8 out via 0x28", gpio_out, 16'h0F0F);
    check("R9 chg via 0x28", gpio_chg, 16'h0FF0);
    wr(12'h028, 32'h0000_0F0F);
    check("R9 same value no flags", gpio_chg, 16'h0000);
  endtask

  task automatic t_pins();
    pins(16'hF000, 16'hF000);
    check("R10 out held after pin set", gpio_out, 16'h0F0F);
    check("R10 no flags on pin set", gpio_chg, 16'h0000);
    rd_chk("R10 level after pin set", 12'h024, 16'hFF0F);
    pins(16'h0001, 16'h0000);
    rd_chk("R10 level after pin clear", 12'h028, 16'hFF0E);
    check("R10 out held after pin clear", gpio_out, 16'h0F0F);
    wr(12'h020, 32'h0000_FFFF);
    check("R8 pins reach out on dir write", gpio_out, 16'hFF0E);
    check("R9 flags after pin merge", gpio_chg, 16'hF001);
    wr(12'h020, 32'h0000_0000);
    check("R8 all inputs", gpio_out, 16'h0000);
    check("R9 all drop", gpio_chg, 16'hFF0E);
    pins(16'h8000, 16'h0000);
    pins(16'h0020, 16'h0020);
    rd_chk("R10 pins ignore direction", 12'h024, 16'h7F2E);
    check("R10 out still zero", gpio_out, 16'h0000);
  endtask

  task automatic t_priority();
    wr(12'h020, 32'h0000_FFFF);
    check("R8 out restore", gpio_out, 16'h7F2E);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 12'h024; bus_wdata = 32'h0000_00F0;
    pin_upd = 16'h000F; pin_val = 16'h000F;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; pin_upd = '0;
    check("R11 bus wins out", gpio_out, 16'h00F0);
    check("R11 bus wins chg", gpio_chg, 16'h7FDE);
    rd_chk("R11 bus wins level", 12'h024, 16'h00F0);
  endtask

  task automatic t_latency();
    logic [15:0] v;
    rd(12'h008, v);
    check("R12 status read", v, 16'h0002);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 12'h004;
    #1;
    check("R12 not yet updated", bus_rdata, 16'h0002);
    @(negedge clk);
    bus_sel = 0;
    check("R12 updated after edge", bus_rdata, 16'h5A5A);
    wr(12'h000, 32'h0000_7777);
    check("R12 holds through write", bus_rdata, 16'h5A5A);
    repeat (2) @(negedge clk);
    check("R12 holds idle", bus_rdata, 16'h5A5A);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    pin_upd = '0; pin_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_power();
    t_status();
    t_alias();
    t_undecoded();
    t_gpio();
    t_pins();
    t_priority();
    t_latency();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule